// File: doc/BRIEF.md
# Programmable AND / Fixed OR Logic Array

This block is a small field-configurable two-level logic array. Four primary variables enter a programmable AND plane of twelve product terms. The terms are split into four fixed groups of three, and each group is ORed onto one output. Each product term chooses, through one connection bit per literal, which of the true and complemented forms of the variables it includes. A connection that is present puts that literal into the AND. A missing connection leaves it out.

The output of the first group is also fed back into the AND plane as a fifth variable, called W. Terms of the other three groups may use W or its complement. A function that needs more than three product terms can therefore be factored: part of it is built in the first group as W, and the rest combines W with further terms. To rule out a combinational loop, the terms of the W group cannot see W at all.

The 120 connection bits are held in a shift register. They are loaded one bit per clock through a serial data pin while a load strobe is high. The outputs are a purely combinational function of the inputs and the stored bits. They therefore follow the configuration as it shifts in.

Top module: `pal_array`

## Requirements
- R1: A synchronous active-high reset sets every stored connection bit to 1 (all literals connected). Every product term then holds a literal and its complement, so all four outputs are 0 for every input value.
- R2: The stored bit for product term t (0..11) and column c (0..9) sits at index t*10+c. While `cfg_load` is 1, each rising clock edge moves every stored bit up one index and writes `cfg_din` into index 0. After 120 loading cycles, the first bit shifted in is at index 119 (term 11, column 9).
- R3: While `cfg_load` is 0, the stored configuration is kept unchanged, whatever `cfg_din` does.
- R4: Variable v has two columns: column 2v is its true form and column 2v+1 is its complement. The variables are A=`in_vars[0]`, B=`in_vars[1]`, C=`in_vars[2]`, D=`in_vars[3]` and W (v=4). A stored 1 includes the literal in the term and a stored 0 excludes it.
- R5: Each product term is the AND of its included literals. Output `f_out[k]` is the OR of product terms 3k, 3k+1 and 3k+2.
- R6: A product term with no literal included evaluates to 1.
- R7: A product term with every literal included evaluates to 0, because it contains both forms of a variable.
- R8: W equals `f_out[0]`. Terms 3..11 use W through columns 8 and 9 in the same way as any primary variable.
- R9: For terms 0..2 (the W group), the bits in columns 8 and 9 are ignored, so W never depends on itself.
- R10: The outputs follow `in_vars` without a clock. After every clock edge they reflect the configuration stored at that edge, including during loading.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration register |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Shift enable for the configuration register |
| cfg_din | input | 1 | Serial configuration bit, most significant index first |
| in_vars | input | 4 | Primary variables A (bit 0) to D (bit 3) |
| f_out | output | 4 | Group OR outputs; bit 0 is also the feedback W |

## Verification
Configuration shifting and logic evaluation can happen in the same cycle, because the outputs keep responding while a new pattern is still moving through the register. The bench changes the input variables while it streams every configuration in. After each edge it compares the outputs against a behavioural model whose own copy of the bits shifts in the same way. A wrong shift direction or a wrong row order therefore shows up as an output mismatch part-way through a load, as well as in the final truth tables.

// File: rtl/pal_pkg.sv
package pal_pkg;

    localparam int N_IN      = 4;
    localparam int N_VARS    = N_IN + 1;
    localparam int N_COLS    = 2 * N_VARS;
    localparam int N_OUT     = 4;
    localparam int TPO       = 3;
    localparam int N_TERMS   = N_OUT * TPO;
    localparam int CFG_BITS  = N_TERMS * N_COLS;
    localparam int GRP_BITS  = TPO * N_COLS;

    typedef logic [N_IN-1:0]     invec_t;
    typedef logic [N_COLS-1:0]   litvec_t;
    typedef logic [CFG_BITS-1:0] cfgvec_t;

    typedef struct packed {
        logic fb_bar;
        logic fb;
        logic [2*N_IN-1:0] prim;
    } lits_t;

    function automatic logic [2*N_IN-1:0] prim_literals(input invec_t x);
        logic [2*N_IN-1:0] l;
        for (int v = 0; v < N_IN; v++) begin
            l[2*v]   = x[v];
            l[2*v+1] = ~x[v];
        end
        return l;
    endfunction

endpackage

// File: rtl/pal_cfg_shift.sv
module pal_cfg_shift #(
    parameter int BITS = 120
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            din,
    output logic [BITS-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '1;
        end else if (load) begin
            q <= {q[BITS-2:0], din};
        end
    end

endmodule

// File: rtl/pal_and_plane.sv
module pal_and_plane #(
    parameter int NT = 3,
    parameter int NC = 10
) (
    input  logic [NT*NC-1:0] conn,
    input  logic [NC-1:0]    lits,
    output logic [NT-1:0]    prod
);

    for (genvar t = 0; t < NT; t++) begin : g_term
        // a literal only pulls the term low when it is connected and false
        assign prod[t] = &(lits | ~conn[t*NC +: NC]);
    end

endmodule

// File: rtl/pal_or_plane.sv
module pal_or_plane #(
    parameter int NG  = 1,
    parameter int TPG = 3
) (
    input  logic [NG*TPG-1:0] prod,
    output logic [NG-1:0]     sums
);

    for (genvar g = 0; g < NG; g++) begin : g_grp
        assign sums[g] = |prod[g*TPG +: TPG];
    end

endmodule

// File: rtl/pal_array.sv
module pal_array
    import pal_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_load,
    input  logic            cfg_din,
    input  logic [N_IN-1:0] in_vars,
    output logic [N_OUT-1:0] f_out
);

    localparam int REST_GRPS  = N_OUT - 1;
    localparam int REST_TERMS = REST_GRPS * TPO;

    cfgvec_t cfg_q;
    lits_t   lits_fb_grp;
    lits_t   lits_rest;
    logic [TPO-1:0]        prod_fb;
    logic [REST_TERMS-1:0] prod_rest;
    logic                  w_sum;
    logic [REST_GRPS-1:0]  rest_sums;

    pal_cfg_shift #(.BITS(CFG_BITS)) u_cfg (
        .clk  (clk),
        .rst  (rst),
        .load (cfg_load),
        .din  (cfg_din),
        .q    (cfg_q)
    );

    // W group: feedback literals tied high so their connection bits drop out
    always_comb begin
        lits_fb_grp.prim   = prim_literals(in_vars);
        lits_fb_grp.fb     = 1'b1;
        lits_fb_grp.fb_bar = 1'b1;
    end

    pal_and_plane #(.NT(TPO), .NC(N_COLS)) u_and_fb (
        .conn (cfg_q[GRP_BITS-1:0]),
        .lits (lits_fb_grp),
        .prod (prod_fb)
    );

    pal_or_plane #(.NG(1), .TPG(TPO)) u_or_fb (
        .prod (prod_fb),
        .sums (w_sum)
    );

    always_comb begin
        lits_rest.prim   = prim_literals(in_vars);
        lits_rest.fb     = w_sum;
        lits_rest.fb_bar = ~w_sum;
    end

    pal_and_plane #(.NT(REST_TERMS), .NC(N_COLS)) u_and_rest (
        .conn (cfg_q[CFG_BITS-1:GRP_BITS]),
        .lits (lits_rest),
        .prod (prod_rest)
    );

    pal_or_plane #(.NG(REST_GRPS), .TPG(TPO)) u_or_rest (
        .prod (prod_rest),
        .sums (rest_sums)
    );

    assign f_out = {rest_sums, w_sum};

endmodule

// File: rtl/pal_array_chk.sv
module pal_array_chk
    import pal_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic             cfg_din,
    input  logic [CFG_BITS-1:0] cfg_q,
    input  logic [N_OUT-1:0] f_out
);

    p_reset_intact_r1: assert property (@(posedge clk)
        rst |=> (&cfg_q));

    p_shift_in_r2: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> cfg_q == {$past(cfg_q[CFG_BITS-2:0]), $past(cfg_din)});

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !cfg_load |=> $stable(cfg_q));

    p_all_intact_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (&cfg_q) |-> (f_out == '0));

    for (genvar g = 1; g < N_OUT; g++) begin : g_empty
        p_empty_term_one_r6: assert property (@(posedge clk) disable iff (rst)
            (cfg_q[g*GRP_BITS +: N_COLS] == '0) |-> f_out[g]);
    end

    // W group term with only the feedback columns set is an empty term
    p_fb_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[2*N_IN-1:0] == '0) |-> f_out[0]);

endmodule

bind pal_array pal_array_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .cfg_load (cfg_load),
    .cfg_din  (cfg_din),
    .cfg_q    (cfg_q),
    .f_out    (f_out)
);

// File: tb/pal_array_tb.sv
`timescale 1ns/1ps
module pal_array_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_load = 1'b0;
    logic       cfg_din = 1'b0;
    logic [3:0] in_vars = 4'd0;
    logic [3:0] f_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit mcfg [120];
    bit pat  [120];

    pal_array u_dut (
        .clk      (clk),
        .rst      (rst),
        .cfg_load (cfg_load),
        .cfg_din  (cfg_din),
        .in_vars  (in_vars),
        .f_out    (f_out)
    );

    always #2.5 clk = ~clk;

    // behavioural sum-of-products model over the bench's own bit array
    function automatic logic [3:0] model_eval(input logic [3:0] x);
        logic [3:0] r;
        logic w, s, p, val;
        int t;
        r = 4'd0;
        w = 1'b0;
        for (int g = 0; g < 4; g++) begin
            s = 1'b0;
            for (int k = 0; k < 3; k++) begin
                t = g*3 + k;
                p = 1'b1;
                for (int v = 0; v < 5; v++) begin
                    if (!(v == 4 && g == 0)) begin
                        val = (v < 4) ? x[v] : w;
                        if (mcfg[t*10 + 2*v] && !val) p = 1'b0;
                        if (mcfg[t*10 + 2*v + 1] && val) p = 1'b0;
                    end
                end
                s = s | p;
            end
            r[g] = s;
            if (g == 0) w = s;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: in=%b f_out=%b expected %b", tag, in_vars, act, exp);
        end
    endtask

    task automatic tick();
        if (rst) begin
            foreach (mcfg[i]) mcfg[i] = 1'b1;
        end else if (cfg_load) begin
            for (int i = 119; i > 0; i--) mcfg[i] = mcfg[i-1];
            mcfg[0] = cfg_din;
        end
        @(posedge clk);
        #1;
        check("R10 per-cycle", f_out, model_eval(in_vars));
    endtask

    task automatic load_pat();
        cfg_load = 1'b1;
        for (int i = 119; i >= 0; i--) begin
            cfg_din = pat[i];
            in_vars = 4'(i);
            tick();
        end
        cfg_load = 1'b0;
        cfg_din  = 1'b0;
    endtask

    task automatic pat_fill(input bit v);
        foreach (pat[i]) pat[i] = v;
    endtask

    task automatic pat_row(input int t, input bit v);
        for (int c = 0; c < 10; c++) pat[t*10 + c] = v;
    endtask

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [3:0] e;
        logic a, b, c, d, w;
        tick();
        tick();
        rst = 1'b0;

        // R1: reset leaves every literal connected, outputs 0
        for (int x = 0; x < 16; x++) begin
            in_vars = 4'(x); #1;
            check("R1", f_out, 4'b0000);
        end

        // R2: empty row 11 must land on output 3 (first bit -> index 119)
        pat_fill(1'b1); pat_row(11, 1'b0);
        load_pat();
        for (int x = 0; x < 16; x++) begin
            in_vars = 4'(x); #1;
            check("R2", f_out, 4'b1000);
        end

        // R6: empty term 3 drives output 1 high
        pat_fill(1'b1); pat_row(3, 1'b0);
        load_pat();
        for (int x = 0; x < 16; x++) begin
            in_vars = 4'(x); #1;
            check("R6", f_out, 4'b0010);
        end

        // R4: column mapping, term 6 = B, term 9 = ~D
        pat_fill(1'b1); pat_row(6, 1'b0); pat_row(9, 1'b0);
        pat[6*10 + 2] = 1'b1; pat[9*10 + 7] = 1'b1;
        load_pat();
        for (int x = 0; x < 16; x++) begin
            in_vars = 4'(x); #1;
            e = {~in_vars[3], in_vars[1], 2'b00};
            check("R4", f_out, e);
        end

        // R5: output 1 = A&B | C&~D
        pat_fill(1'b1); pat_row(3, 1'b0); pat_row(4, 1'b0);
        pat[30] = 1'b1; pat[32] = 1'b1; pat[44] = 1'b1; pat[47] = 1'b1;
        load_pat();
        for (int x = 0; x < 16; x++) begin
            in_vars = 4'(x); #1;
            a = in_vars[0]; b = in_vars[1]; c = in_vars[2]; d = in_vars[3];
            e = {2'b00, (a & b) | (c & ~d), 1'b0};
            check("R5", f_out, e);
        end

        // R8: W = A&B, out1 = ~W, out2 = W&C
        pat_fill(1'b1); pat_row(0, 1'b0); pat_row(3, 1'b0); pat_row(6, 1'b0);
        pat[0] = 1'b1; pat[2] = 1'b1; pat[39] = 1'b1; pat[68] = 1'b1; pat[64] = 1'b1;
        load_pat();
        for (int x = 0; x < 16; x++) begin
            in_vars = 4'(x); #1;
            a = in_vars[0]; b = in_vars[1]; c = in_vars[2];
            w = a & b;
            e = {1'b0, w & c, ~w, w};
            check("R8", f_out, e);
        end

        // R9: W-group term with only columns 8/9 set acts as empty
        pat_fill(1'b1); pat_row(0, 1'b0); pat_row(3, 1'b0);
        pat[8] = 1'b1; pat[9] = 1'b1; pat[38] = 1'b1;
        load_pat();
        for (int x = 0; x < 16; x++) begin
            in_vars = 4'(x); #1;
            check("R9", f_out, 4'b0011);
        end

        // R3: toggling serial data with load low changes nothing
        for (int i = 0; i < 30; i++) begin
            cfg_din = 1'($urandom);
            in_vars = 4'($urandom);
            tick();
        end
        cfg_din = 1'b0;
        for (int x = 0; x < 16; x++) begin
            in_vars = 4'(x); #1;
            check("R3", f_out, 4'b0011);
        end

        // R7: fully connected group 1 stays 0, empty groups are 1
        pat_fill(1'b0); pat_row(3, 1'b1); pat_row(4, 1'b1); pat_row(5, 1'b1);
        load_pat();
        for (int x = 0; x < 16; x++) begin
            in_vars = 4'(x); #1;
            check("R7", f_out, 4'b1101);
        end

        // R5/R10: random legal configurations against the model
        for (int n = 0; n < 24; n++) begin
            foreach (pat[i]) pat[i] = ($urandom % 4) == 0;
            for (int t = 0; t < 3; t++) begin
                pat[t*10 + 8] = 1'b0;
                pat[t*10 + 9] = 1'b0;
            end
            load_pat();
            for (int x = 0; x < 16; x++) begin
                in_vars = 4'(x); #1;
                check("R5 random", f_out, model_eval(in_vars));
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule